// File: doc/BRIEF.md
# ADC result register bank

This block sits between a 10-bit, eight-input successive-approximation converter and a CPU bus. Each finished conversion arrives on a valid/ready result port together with the number of the input it came from. The block stores the result in a pair of read-only byte registers, and the CPU reads those bytes over a byte-wide read port with a 4-bit byte address. Read data is combinational, so it is valid in the same cycle as the address.

There are two placement schemes. Normally a result from input k goes to register pair k. When fixed-channel repeat mode is on and the interrupt-mode select is also 1, successive results fill pairs 0, 1, 2 and 3 in turn, and the input number is ignored. Each pair carries a storage flag in bit 0 of its lower byte. A single end-of-conversion flag, with a one-cycle interrupt pulse, reports new data. Reading a result clears the flags.

A small state counter models the time one conversion takes. It signals completion after 84 enabled state ticks. The result port is accepted in every cycle except the one in which the mode inputs change. In that cycle `res_ready` is low and a result offered there is not taken. A producer holds `res_valid` and its data until it sees `res_ready` high at a clock edge.

Top module: `adc_result_bank`

## Requirements
- R1: When rotation is off, an accepted result with input number k (0 to 7) is stored in register pair k, and no other pair changes.
- R2: Rotation is on only when `mode_fixed_rep` and `irq_sel` are both 1. Accepted results then go to pairs 0, 1, 2, 3, 0, ... and `res_chan` is ignored. With only `mode_fixed_rep` set, placement follows R1.
- R3: The storage flag of a pair, at bit 0 of its lower byte, reads 1 from the cycle after a result is stored into that pair.
- R4: A read strobe (`rd_en`=1) at either byte of pair p clears the flag of pair p at the next edge and leaves the flags of the other pairs unchanged. With `rd_en`=0 the address only selects data and changes nothing.
- R5: Any read strobe clears `eoc_flag` at the next edge.
- R6: If a result is stored into a pair in the same cycle as a read of that pair, the flag stays 1, and so does `eoc_flag` when that store sets it.
- R7: After `conv_start`, `conv_done` is high for exactly one cycle, following the edge that samples the 84th cycle with `tick_en`=1. Cycles with `tick_en`=0 do not count.
- R8: Byte address = pair*2 + 0 for the lower byte or + 1 for the upper byte. The upper byte is result bits 9..2. The lower byte is {result bits 1..0, 5'b0, flag}.
- R9: When rotation is off, every stored result sets `eoc_flag` and pulses `eoc_irq` for one cycle after the store edge. When rotation is on, this happens only on the store into slot 3.
- R10: A change of either mode input drops `res_ready` for that cycle. At the next edge it clears all storage flags and `eoc_flag` and returns the slot pointer to 0. Stored data is kept.
- R11: After reset every byte reads 0, both flags are 0 and `res_ready` is 1 while the mode inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fixed_rep | input | 1 | Fixed-channel repeat mode select |
| irq_sel | input | 1 | Interrupt-mode select; together with the line above it enables rotation |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result accepted at this edge if valid |
| res_chan | input | 3 | Input number of the result |
| res_data | input | 10 | Conversion result |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 4 | Byte address |
| rd_data | output | 8 | Byte read data, same cycle |
| eoc_flag | output | 1 | End-of-conversion flag |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| conv_start | input | 1 | Starts the conversion state counter |
| tick_en | input | 1 | State tick enable |
| conv_done | output | 1 | One-cycle conversion-complete pulse |

## Verification
A wrong slot pointer shows up as data in the wrong pair at the first rotating store, and as an `eoc_irq` on the wrong store. Both can be seen on the cycle after the store edge. A flag that is wrong after a store, read or mode change shows in bit 0 of the lower byte as soon as that byte is addressed, which is one cycle after the event. A miscounting state counter moves `conv_done` off the cycle after the 84th tick, or stretches it past one cycle.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  localparam int unsigned BANK_PAIRS = 8;
  localparam int unsigned BANK_RES_W = 10;
  localparam int unsigned BANK_SLOTS = 4;
  localparam int unsigned BANK_CONV  = 84;

  // lower byte: leftover low result bits at the top, zero fill, flag in bit 0
  function automatic logic [7:0] pack_low(input logic [BANK_RES_W-1:0] r, input logic flag);
    logic [7:0] b;
    b = '0;
    b[7 -: (BANK_RES_W-8)] = r[BANK_RES_W-9:0];
    b[0] = flag;
    return b;
  endfunction
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_STATES = 84
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(CONV_STATES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && tick) begin
        if (cnt_q == CNT_W'(CONV_STATES - 1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done = done_q;
endmodule

// File: rtl/adc_slot_ctrl.sv
module adc_slot_ctrl #(
  parameter int unsigned N_PAIR = 8,
  parameter int unsigned N_SLOT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fixed_rep,
  input  logic                      irq_sel,
  input  logic [$clog2(N_PAIR)-1:0] chan,
  input  logic                      acc,
  output logic                      ready,
  output logic                      mode_chg,
  output logic                      rot_mode,
  output logic [$clog2(N_PAIR)-1:0] wr_idx,
  output logic                      last_slot,
  output logic [$clog2(N_SLOT)-1:0] ptr
);
  localparam int unsigned IDX_W  = $clog2(N_PAIR);
  localparam int unsigned SLOT_W = $clog2(N_SLOT);

  logic [1:0]        cfg_q;
  logic [SLOT_W-1:0] ptr_q;

  assign mode_chg  = ({fixed_rep, irq_sel} != cfg_q);
  assign ready     = !mode_chg;
  assign rot_mode  = (cfg_q == 2'b11);
  assign last_slot = rot_mode && (ptr_q == SLOT_W'(N_SLOT - 1));
  assign wr_idx    = rot_mode ? IDX_W'(ptr_q) : chan;
  assign ptr       = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 2'b00;
      ptr_q <= '0;
    end else if (mode_chg) begin
      cfg_q <= {fixed_rep, irq_sel};
      ptr_q <= '0;
    end else if (acc && rot_mode) begin
      ptr_q <= last_slot ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int unsigned N_PAIR = 8,
  parameter int unsigned RES_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      wr_en,
  input  logic [$clog2(N_PAIR)-1:0] wr_idx,
  input  logic [RES_W-1:0]          wr_data,
  input  logic                      rd_en,
  input  logic [$clog2(N_PAIR)-1:0] rd_idx,
  input  logic                      rd_hi,
  output logic [7:0]                rd_data,
  output logic [N_PAIR-1:0]         flag_vec
);
  localparam int unsigned IDX_W = $clog2(N_PAIR);

  logic [RES_W-1:0]  data_q [N_PAIR];
  logic [N_PAIR-1:0] flag_q;

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    logic hit_wr, hit_rd;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(i));
    assign hit_rd = rd_en && (rd_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q[i] <= '0;
      else if (hit_wr) data_q[i] <= wr_data;
    end

    // store beats a same-cycle read of the same pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[i] <= 1'b0;
      else if (clr_all) flag_q[i] <= 1'b0;
      else if (hit_wr)  flag_q[i] <= 1'b1;
      else if (hit_rd)  flag_q[i] <= 1'b0;
    end
  end

  always_comb begin
    if (rd_hi) rd_data = data_q[rd_idx][RES_W-1 -: 8];
    else       rd_data = adc_bank_pkg::pack_low(data_q[rd_idx], flag_q[rd_idx]);
  end

  assign flag_vec = flag_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned N_PAIR      = adc_bank_pkg::BANK_PAIRS,
  parameter int unsigned RES_W       = adc_bank_pkg::BANK_RES_W,
  parameter int unsigned N_SLOT      = adc_bank_pkg::BANK_SLOTS,
  parameter int unsigned CONV_STATES = adc_bank_pkg::BANK_CONV
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_fixed_rep,
  input  logic                        irq_sel,
  input  logic                        res_valid,
  output logic                        res_ready,
  input  logic [$clog2(N_PAIR)-1:0]   res_chan,
  input  logic [RES_W-1:0]            res_data,
  input  logic                        rd_en,
  input  logic [$clog2(N_PAIR):0]     rd_addr,
  output logic [7:0]                  rd_data,
  output logic                        eoc_flag,
  output logic                        eoc_irq,
  input  logic                        conv_start,
  input  logic                        tick_en,
  output logic                        conv_done
);
  localparam int unsigned IDX_W  = $clog2(N_PAIR);
  localparam int unsigned SLOT_W = $clog2(N_SLOT);

  logic              acc, mode_chg, rot_q, last_slot, set_evt;
  logic [IDX_W-1:0]  wr_idx;
  logic [SLOT_W-1:0] ptr_q;
  logic [N_PAIR-1:0] flag_vec;
  logic              eoc_q, irq_q;

  assign acc     = res_valid && res_ready;
  assign set_evt = acc && (!rot_q || last_slot);

  adc_slot_ctrl #(.N_PAIR(N_PAIR), .N_SLOT(N_SLOT)) u_slot (
    .clk(clk), .rst_n(rst_n), .fixed_rep(mode_fixed_rep), .irq_sel(irq_sel),
    .chan(res_chan), .acc(acc), .ready(res_ready), .mode_chg(mode_chg),
    .rot_mode(rot_q), .wr_idx(wr_idx), .last_slot(last_slot), .ptr(ptr_q)
  );

  adc_result_store #(.N_PAIR(N_PAIR), .RES_W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(mode_chg), .wr_en(acc), .wr_idx(wr_idx),
    .wr_data(res_data), .rd_en(rd_en), .rd_idx(rd_addr[IDX_W:1]),
    .rd_hi(rd_addr[0]), .rd_data(rd_data), .flag_vec(flag_vec)
  );

  adc_conv_timer #(.CONV_STATES(CONV_STATES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .tick(tick_en), .done(conv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= set_evt;
      if (mode_chg)     eoc_q <= 1'b0;
      else if (set_evt) eoc_q <= 1'b1;
      else if (rd_en)   eoc_q <= 1'b0;
    end
  end

  assign eoc_flag = eoc_q;
  assign eoc_irq  = irq_q;
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int unsigned N_PAIR = 8,
  parameter int unsigned N_SLOT = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      res_valid,
  input logic                      res_ready,
  input logic                      rd_en,
  input logic [$clog2(N_PAIR)-1:0] rd_pair,
  input logic                      eoc_flag,
  input logic                      eoc_irq,
  input logic                      conv_done,
  input logic                      rot_q,
  input logic [$clog2(N_SLOT)-1:0] ptr_q,
  input logic [$clog2(N_PAIR)-1:0] wr_idx,
  input logic [N_PAIR-1:0]         flag_vec
);
  logic acc;
  assign acc = res_valid && res_ready;

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> flag_vec[$past(wr_idx)]);

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc) |=> !flag_vec[$past(rd_pair)]);

  // R5
  eoc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc) |=> !eoc_flag);

  // R9
  irq_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> eoc_flag);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rot_q && ptr_q == ($clog2(N_SLOT))'(N_SLOT - 1)) |=> (ptr_q == '0));

  // R10
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |=> (flag_vec == '0 && !eoc_flag && ptr_q == '0));
endmodule

bind adc_result_bank adc_result_bank_chk #(.N_PAIR(N_PAIR), .N_SLOT(N_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .rd_en(rd_en), .rd_pair(rd_addr[$clog2(N_PAIR):1]), .eoc_flag(eoc_flag),
  .eoc_irq(eoc_irq), .conv_done(conv_done), .rot_q(rot_q), .ptr_q(ptr_q),
  .wr_idx(wr_idx), .flag_vec(flag_vec)
);

// File: tb/adc_result_bank_test.sv
module adc_result_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_fixed_rep = 1'b0, irq_sel = 1'b0;
  logic       res_valid = 1'b0, res_ready;
  logic [2:0] res_chan = '0;
  logic [9:0] res_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       eoc_flag, eoc_irq;
  logic       conv_start = 1'b0, tick_en = 1'b0, conv_done;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [9:0] m_data [8];
  logic [7:0] m_flag;
  logic       m_eoc, m_rot;
  int         m_ptr;

  always #5 clk = ~clk;

  adc_result_bank uut (
    .clk(clk), .rst_n(rst_n), .mode_fixed_rep(mode_fixed_rep), .irq_sel(irq_sel),
    .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
    .res_data(res_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .eoc_flag(eoc_flag), .eoc_irq(eoc_irq), .conv_start(conv_start),
    .tick_en(tick_en), .conv_done(conv_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic check_pair(input string req, input int p);
    logic [7:0] d;
    peek(4'(p * 2 + 1), d);
    check({req, " upper"}, 32'(d), 32'(m_data[p][9:2]));
    peek(4'(p * 2), d);
    check({req, " lower"}, 32'(d), 32'({m_data[p][1:0], 5'b0, m_flag[p]}));
  endtask

  task automatic push(input logic [2:0] ch, input logic [9:0] dat, input string req);
    int idx;
    bit ev;
    @(negedge clk);
    res_valid = 1'b1; res_chan = ch; res_data = dat;
    @(posedge clk); #1;
    res_valid = 1'b0;
    idx = m_rot ? m_ptr : int'(ch);
    m_data[idx] = dat; m_flag[idx] = 1'b1;
    ev = !m_rot || (m_ptr == 3);
    if (ev) m_eoc = 1'b1;
    if (m_rot) m_ptr = (m_ptr + 1) % 4;
    check({req, " irq"}, 32'(eoc_irq), 32'(ev));
    check({req, " eoc"}, 32'(eoc_flag), 32'(m_eoc));
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
    m_flag[a[3:1]] = 1'b0; m_eoc = 1'b0;
  endtask

  task automatic set_mode(input logic f, input logic s);
    @(negedge clk);
    mode_fixed_rep = f; irq_sel = s;
    #1 check("R10 ready low on mode change", 32'(res_ready), 32'(0));
    @(posedge clk); #1;
    m_flag = '0; m_eoc = 1'b0; m_ptr = 0; m_rot = f & s;
    check("R10 eoc cleared", 32'(eoc_flag), 32'(0));
    check("R10 ready back", 32'(res_ready), 32'(1));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      peek(4'(a), d);
      check("R11 reset byte", 32'(d), 32'(0));
    end
    check("R11 reset eoc", 32'(eoc_flag), 32'(0));
    check("R11 reset irq", 32'(eoc_irq), 32'(0));
    check("R11 reset ready", 32'(res_ready), 32'(1));
  endtask

  task automatic t_by_channel();
    logic [9:0] pats [8] = '{10'h3FF, 10'h001, 10'h2AA, 10'h155, 10'h200, 10'h0C3, 10'h303, 10'h1FE};
    for (int k = 7; k >= 0; k--) push(3'(k), pats[k], "R9 store");
    for (int p = 0; p < 8; p++) check_pair("R1 R3 R8 placement", p);
  endtask

  task automatic t_read_clear();
    logic [7:0] d;
    bus_read(4'd7, d);
    check("R8 upper via strobe", 32'(d), 32'(m_data[3][9:2]));
    check("R5 eoc cleared by read", 32'(eoc_flag), 32'(0));
    check_pair("R4 pair3 after upper read", 3);
    check_pair("R4 pair4 untouched", 4);
    bus_read(4'd10, d);
    check("R8 lower via strobe", 32'(d), 32'({m_data[5][1:0], 5'b0, 1'b1}));
    check_pair("R4 pair5 after lower read", 5);
    check_pair("R4 pair6 untouched", 6);
  endtask

  task automatic t_collide();
    @(negedge clk);
    res_valid = 1'b1; res_chan = 3'd2; res_data = 10'h2C7;
    rd_en = 1'b1; rd_addr = 4'd4;
    @(posedge clk); #1;
    res_valid = 1'b0; rd_en = 1'b0;
    m_data[2] = 10'h2C7; m_flag[2] = 1'b1; m_eoc = 1'b1;
    check("R6 eoc kept on collision", 32'(eoc_flag), 32'(1));
    check_pair("R6 flag kept on collision", 2);
  endtask

  task automatic t_rotate();
    logic [9:0] old7;
    set_mode(1'b1, 1'b0);
    push(3'd6, 10'h111, "R2 half mode");
    check_pair("R2 half mode by channel", 6);
    old7 = m_data[7];
    set_mode(1'b1, 1'b1);
    check_pair("R10 flags cleared data kept", 6);
    for (int i = 0; i < 6; i++) push(3'd7, 10'(10'h040 + i * 37), "R9 R2 rotate");
    for (int p = 0; p < 4; p++) check_pair("R2 rotated slot", p);
    check("R2 channel ignored", 32'(m_data[7]), 32'(old7));
    check_pair("R2 pair7 unchanged", 7);
    set_mode(1'b0, 1'b1);
    set_mode(1'b1, 1'b1);
    push(3'd5, 10'h3A5, "R10 pointer reset");
    check_pair("R10 store lands in slot 0", 0);
  endtask

  task automatic t_timer();
    int early = 0;
    @(negedge clk); conv_start = 1'b1;
    @(posedge clk); #1 conv_start = 1'b0;
    for (int i = 0; i < 84; i++) begin
      if (i % 10 == 3) begin
        @(negedge clk); tick_en = 1'b0;
        @(posedge clk); #1;
        if (conv_done) early++;
      end
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); #1 tick_en = 1'b0;
      if (i < 83 && conv_done) early++;
    end
    check("R7 done at 84th tick", 32'(conv_done), 32'(1));
    check("R7 no early done", 32'(early), 32'(0));
    @(posedge clk); #1;
    check("R7 done one cycle", 32'(conv_done), 32'(0));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_data[i] = '0;
    m_flag = '0; m_eoc = 1'b0; m_rot = 1'b0; m_ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_by_channel();
    t_read_clear();
    t_collide();
    t_rotate();
    t_timer();
    finish_run();
  end
endmodule